// File: doc/BRIEF.md
# Multi-block data transfer sequencer

This block runs the data phase of a memory-card transfer made of one or more equal-sized blocks. A start pulse latches three settings: a block-size exponent, a block-count field and a total byte count. The block then passes bytes in either direction between two valid/ready byte streams. It counts the bytes of each block and counts the blocks.

When a block's data is complete, the block deals with the checksum. In the card-write direction it appends a 16-bit CRC and then waits for a status token from the card. In the card-read direction it takes two CRC bytes off the input stream, keeps them off the output stream, and compares them with its own result. A block is reported done only when its check passes. When the last block is done, the block signals end of transfer. If the transfer was marked open-ended, it also asks the command logic to issue a STOP command.

States: `ST_IDLE` waits for start. `ST_DATA` moves the block's bytes. `ST_CRC_HI` and `ST_CRC_LO` move the two checksum bytes. `ST_TOKEN` waits for the write status token. The transitions are:
- start with good settings: `ST_IDLE` to `ST_DATA`.
- last data byte: `ST_DATA` to `ST_CRC_HI`.
- upper CRC byte moved: `ST_CRC_HI` to `ST_CRC_LO`.
- lower CRC byte moved: `ST_CRC_LO` to `ST_TOKEN` on writes. On reads it goes to `ST_DATA` for a further block, or to `ST_IDLE` after the last block or on a mismatch.
- token seen: `ST_TOKEN` to `ST_DATA` or `ST_IDLE` by the same rule.

Top module: `mblk_seq`

## Requirements
- R1: With a non-zero block-count field N, N+1 blocks are moved, each 2^E bytes long, where E is the size exponent.
- R2: With a block-count field of zero, the size exponent has no effect, and one block of exactly xfer_cnt bytes is moved.
- R3: A start is refused with cfg_err set and busy kept low if either of these holds: the block-count field is non-zero and xfer_cnt differs from 2^E*(N+1), or the block-count field is zero and xfer_cnt is zero. The flag is cleared by the next start.
- R4: Writes: each data byte taken on the input stream is sent unchanged on the output stream. The block's CRC follows, upper byte first. The CRC is CRC-16 with polynomial 0x1021, initial value 0, data processed most significant bit first.
- R5: Writes: after the CRC the block waits on tok_valid. A tok_code of 3'b010 completes the block. Any other code sets crc_err and returns to idle with no blk_done for that block.
- R6: Reads: data bytes pass from input to output. The two CRC bytes that follow are consumed, upper byte first, and never appear at the output. A match gives a one-cycle blk_done.
- R7: Reads: a CRC mismatch sets crc_err and returns to idle. Neither blk_done nor xfer_done is raised for that block.
- R8: xfer_done is a one-cycle pulse that coincides with the final blk_done. busy is already low when it appears, and a new start is accepted afterwards.
- R9: stop_req pulses together with xfer_done only when open_ended was set at start.
- R10: Bytes move only on cycles where valid and ready are both high. Stalls on either side change neither the byte sequence nor the block boundaries.
- R11: While busy is low, in_ready and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, acted on in idle only |
| dir_write | input | 1 | 1 = bytes go to the card, 0 = bytes come from the card |
| open_ended | input | 1 | Request STOP after the last block |
| size_exp | input | 4 | Block length exponent |
| blk_cnt | input | 8 | Block-count field (blocks minus one; zero selects raw mode) |
| xfer_cnt | input | 16 | Total byte count |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted by receiver |
| out_data | output | 8 | Output byte |
| tok_valid | input | 1 | Write status token present |
| tok_code | input | 3 | Write status token value |
| busy | output | 1 | Transfer in progress |
| blk_done | output | 1 | One-cycle pulse per good block |
| xfer_done | output | 1 | One-cycle pulse at end of transfer |
| stop_req | output | 1 | One-cycle STOP request |
| cfg_err | output | 1 | Settings were inconsistent at last start |
| crc_err | output | 1 | CRC or status token failure in last transfer |

## Verification
Transfers are run in both directions, in multi-block mode and in raw mode. Raw mode uses an exponent that would give a different length if it were applied, so it shows whether the exponent is really ignored. Some runs have no stalls and others stall both streams in fixed patterns. Comparing the two shows that the counters advance only on real handshakes. A corrupted CRC on a middle block, and a rejected token on the first block, show how far the block gets before an error. Starts with mismatched or zero counts show that a transfer is refused without any byte moving.

// File: rtl/mblk_pkg.sv
package mblk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_TOKEN
    } mblk_state_e;

    localparam logic [2:0]  TOKEN_GOOD = 3'b010;
    localparam logic [15:0] CRC_POLY   = 16'h1021;

    // Fold one byte into the CRC, most significant bit first
    function automatic logic [15:0] crc_fold(input logic [15:0] crc_in, input logic [7:0] b);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int k = 7; k >= 0; k--) begin
            fb = c[15] ^ b[k];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/mblk_cfg.sv
module mblk_cfg #(
    parameter int CNT_W = 16,
    parameter int BC_W  = 8,
    parameter int SZ_W  = 4
) (
    input  logic [SZ_W-1:0]  size_exp,
    input  logic [BC_W-1:0]  blk_cnt,
    input  logic [CNT_W-1:0] xfer_cnt,
    output logic [CNT_W-1:0] blk_len,
    output logic             bad
);
    localparam int PW = CNT_W + BC_W + 1;

    logic [PW-1:0] len_w;
    logic [PW-1:0] prod;
    logic          raw;

    always_comb begin
        raw   = (blk_cnt == '0);
        len_w = PW'(1) << size_exp;
        prod  = len_w * (PW'(blk_cnt) + PW'(1));
        if (raw) begin
            blk_len = xfer_cnt;
            bad     = (xfer_cnt == '0);
        end else begin
            blk_len = len_w[CNT_W-1:0];
            bad     = (32'(size_exp) >= CNT_W) || (prod != PW'(xfer_cnt));
        end
    end
endmodule

// File: rtl/mblk_crc16.sv
module mblk_crc16
    import mblk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (upd) crc <= crc_fold(crc, din);
    end
endmodule

// File: rtl/mblk_counters.sv
module mblk_counters #(
    parameter int CNT_W = 16,
    parameter int BC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] blk_len,
    input  logic [BC_W-1:0]  last_idx,
    input  logic             byte_step,
    input  logic             blk_step,
    output logic             last_byte,
    output logic             last_blk
);
    logic [CNT_W-1:0] len_q, byte_q;
    logic [BC_W-1:0]  nblk_q, blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            nblk_q <= '0;
            byte_q <= '0;
            blk_q  <= '0;
        end else if (load) begin
            len_q  <= blk_len;
            nblk_q <= last_idx;
            byte_q <= '0;
            blk_q  <= '0;
        end else if (blk_step) begin
            byte_q <= '0;
            blk_q  <= blk_q + 1'b1;
        end else if (byte_step) begin
            byte_q <= byte_q + 1'b1;
        end
    end

    assign last_byte = (byte_q == len_q - 1'b1);
    assign last_blk  = (blk_q == nblk_q);
endmodule

// File: rtl/mblk_seq.sv
module mblk_seq
    import mblk_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BC_W  = 8,
    parameter int SZ_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_write,
    input  logic             open_ended,
    input  logic [SZ_W-1:0]  size_exp,
    input  logic [BC_W-1:0]  blk_cnt,
    input  logic [CNT_W-1:0] xfer_cnt,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    input  logic             tok_valid,
    input  logic [2:0]       tok_code,
    output logic             busy,
    output logic             blk_done,
    output logic             xfer_done,
    output logic             stop_req,
    output logic             cfg_err,
    output logic             crc_err
);
    mblk_state_e state_q, state_d;

    logic [CNT_W-1:0] cfg_len;
    logic             cfg_bad;
    logic             wr_q, open_q;
    logic [7:0]       crc_hi_q;
    logic [15:0]      crc;
    logic             last_byte, last_blk;
    logic             in_hs, out_hs, take_start, go_start;
    logic             blk_ok, blk_fail, rd_match;

    mblk_cfg #(.CNT_W(CNT_W), .BC_W(BC_W), .SZ_W(SZ_W)) u_cfg (
        .size_exp(size_exp), .blk_cnt(blk_cnt), .xfer_cnt(xfer_cnt),
        .blk_len(cfg_len), .bad(cfg_bad)
    );

    assign in_hs      = in_valid && in_ready;
    assign out_hs     = out_valid && out_ready;
    assign take_start = start && (state_q == ST_IDLE);
    assign go_start   = take_start && !cfg_bad;
    assign rd_match   = ({crc_hi_q, in_data} == crc);

    always_comb begin
        blk_ok   = 1'b0;
        blk_fail = 1'b0;
        if (state_q == ST_TOKEN && tok_valid) begin
            blk_ok   = (tok_code == TOKEN_GOOD);
            blk_fail = (tok_code != TOKEN_GOOD);
        end else if (state_q == ST_CRC_LO && !wr_q && in_hs) begin
            blk_ok   = rd_match;
            blk_fail = !rd_match;
        end
    end

    mblk_crc16 u_crc (
        .clk(clk), .rst_n(rst_n),
        .clr(go_start || blk_ok),
        .upd((state_q == ST_DATA) && in_hs),
        .din(in_data), .crc(crc)
    );

    mblk_counters #(.CNT_W(CNT_W), .BC_W(BC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(go_start), .blk_len(cfg_len), .last_idx(blk_cnt),
        .byte_step((state_q == ST_DATA) && in_hs),
        .blk_step(blk_ok),
        .last_byte(last_byte), .last_blk(last_blk)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_start) state_d = ST_DATA;
            ST_DATA:   if (in_hs && last_byte) state_d = ST_CRC_HI;
            ST_CRC_HI: if (wr_q ? out_hs : in_hs) state_d = ST_CRC_LO;
            ST_CRC_LO: begin
                if (wr_q && out_hs)   state_d = ST_TOKEN;
                else if (blk_fail)    state_d = ST_IDLE;
                else if (blk_ok)      state_d = last_blk ? ST_IDLE : ST_DATA;
            end
            ST_TOKEN: begin
                if (blk_fail)         state_d = ST_IDLE;
                else if (blk_ok)      state_d = last_blk ? ST_IDLE : ST_DATA;
            end
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Stream outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        unique case (state_q)
            ST_DATA: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = in_data;
            end
            ST_CRC_HI: begin
                out_valid = wr_q;
                in_ready  = !wr_q;
                out_data  = wr_q ? crc[15:8] : 8'h00;
            end
            ST_CRC_LO: begin
                out_valid = wr_q;
                in_ready  = !wr_q;
                out_data  = wr_q ? crc[7:0] : 8'h00;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // Latched settings, pulses and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            open_q    <= 1'b0;
            crc_hi_q  <= '0;
            blk_done  <= 1'b0;
            xfer_done <= 1'b0;
            stop_req  <= 1'b0;
            cfg_err   <= 1'b0;
            crc_err   <= 1'b0;
        end else begin
            blk_done  <= blk_ok;
            xfer_done <= blk_ok && last_blk;
            stop_req  <= blk_ok && last_blk && open_q;
            if (take_start) begin
                cfg_err <= cfg_bad;
                crc_err <= 1'b0;
                wr_q    <= dir_write;
                open_q  <= open_ended;
            end else if (blk_fail) begin
                crc_err <= 1'b1;
            end
            if (state_q == ST_CRC_HI && !wr_q && in_hs) crc_hi_q <= in_data;
        end
    end
endmodule

// File: rtl/mblk_seq_chk.sv
module mblk_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic in_ready,
    input logic out_valid,
    input logic blk_done,
    input logic xfer_done,
    input logic stop_req,
    input logic cfg_err,
    input logic crc_err
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid)); // R11
    AST_DONE_WITH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (blk_done && !busy)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R8
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> xfer_done); // R9
    AST_CFG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !busy); // R3
    AST_CRC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> (!busy && !blk_done && !xfer_done)); // R7
endmodule

bind mblk_seq mblk_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .in_ready(in_ready),
    .out_valid(out_valid), .blk_done(blk_done), .xfer_done(xfer_done),
    .stop_req(stop_req), .cfg_err(cfg_err), .crc_err(crc_err)
);

// File: tb/sim_mblk_seq.sv
`timescale 1ns/1ps
module sim_mblk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_write = 1'b0, open_ended = 1'b0;
    logic [3:0]  size_exp = '0;
    logic [7:0]  blk_cnt = '0;
    logic [15:0] xfer_cnt = '0;
    logic        in_valid = 1'b0, out_ready = 1'b0, tok_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic [2:0]  tok_code = '0;
    logic        in_ready, out_valid, busy, blk_done, xfer_done, stop_req, cfg_err, crc_err;
    logic [7:0]  out_data;

    always #5 clk = ~clk;

    mblk_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .open_ended(open_ended), .size_exp(size_exp), .blk_cnt(blk_cnt),
        .xfer_cnt(xfer_cnt), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .tok_valid(tok_valid), .tok_code(tok_code),
        .busy(busy), .blk_done(blk_done), .xfer_done(xfer_done),
        .stop_req(stop_req), .cfg_err(cfg_err), .crc_err(crc_err)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    byte unsigned src_q[$];
    byte unsigned exp_q[$];
    logic [2:0]   tok_q[$];
    bit  stall = 0, mode_wr = 0, in_took = 0, tok_pend = 0;
    int  wr_len = 0, wr_cnt = 0, n_blk = 0, n_xfer = 0, n_stop = 0, n_out = 0;
    string byte_tag = "R4";

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Reference CRC: long division of the message shifted by 16
    function automatic int ref_crc(input byte unsigned d[$]);
        int r = 0;
        foreach (d[i]) begin
            for (int b = 7; b >= 0; b--) begin
                r = (r << 1) | ((d[i] >> b) & 1);
                if (r & 32'h10000) r = r ^ 32'h11021;
            end
        end
        for (int b = 0; b < 16; b++) begin
            r = r << 1;
            if (r & 32'h10000) r = r ^ 32'h11021;
        end
        return r & 16'hFFFF;
    endfunction

    // Driver: inputs change on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (in_took && src_q.size() > 0) void'(src_q.pop_front());
        in_valid  = (src_q.size() > 0) && (!stall || (cyc % 5) != 3);
        in_data   = (src_q.size() > 0) ? src_q[0] : 8'h00;
        out_ready = !stall || (cyc % 7) != 2;
        if (tok_pend && tok_q.size() > 0) begin
            tok_valid = 1'b1;
            tok_code  = tok_q.pop_front();
            tok_pend  = 0;
        end else begin
            tok_valid = 1'b0;
        end
    end

    // Monitor: every cycle, just before the rising edge
    always @(negedge clk) begin
        #4;
        if (rst_n) begin
            in_took = in_valid && in_ready;
            if (!busy) chk(!in_ready && !out_valid, "R11", "idle handshake lines", {in_ready, out_valid}, 0);
            if (out_valid && out_ready) begin
                n_out++;
                if (exp_q.size() == 0) chk(0, byte_tag, "unexpected output byte", out_data, -1);
                else chk(out_data == exp_q.pop_front(), byte_tag, "output byte", out_data, -1);
                if (mode_wr) begin
                    wr_cnt++;
                    if (wr_cnt == wr_len + 2) begin
                        tok_pend = 1;
                        wr_cnt   = 0;
                    end
                end
            end
            if (blk_done)  n_blk++;
            if (xfer_done) n_xfer++;
            if (stop_req)  n_stop++;
        end
    end

    task automatic run(input bit wr, input bit opn, input int e, input int bc, input int xc,
                       input int bad_blk, input bit stl, input string tag);
        bit raw = (bc == 0);
        int len = raw ? xc : (1 << e);
        int nb  = raw ? 1 : bc + 1;
        bit bad = raw ? (xc == 0) : (len * nb != xc);
        @(posedge clk);
        src_q.delete(); exp_q.delete(); tok_q.delete();
        n_blk = 0; n_xfer = 0; n_stop = 0; n_out = 0; wr_cnt = 0; tok_pend = 0;
        mode_wr = wr; wr_len = len; stall = stl; byte_tag = wr ? "R4" : "R6";
        if (!bad) begin
            for (int b = 0; b < nb; b++) begin
                byte unsigned blk[$];
                int c;
                for (int i = 0; i < len; i++) blk.push_back(8'((b * 37 + i * 11 + xc) & 255));
                c = ref_crc(blk);
                foreach (blk[i]) begin src_q.push_back(blk[i]); exp_q.push_back(blk[i]); end
                if (wr) begin
                    exp_q.push_back(8'(c >> 8)); exp_q.push_back(8'(c));
                    tok_q.push_back(b == bad_blk ? 3'b100 : 3'b010);
                end else begin
                    src_q.push_back(8'(c >> 8));
                    src_q.push_back(b == bad_blk ? 8'(c ^ 1) : 8'(c));
                end
                if (b == bad_blk) break;
            end
        end
        @(negedge clk);
        dir_write = wr; open_ended = opn; size_exp = 4'(e); blk_cnt = 8'(bc); xfer_cnt = 16'(xc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        while (busy) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        chk(cfg_err == bad, "R3", {tag, " cfg_err"}, cfg_err, bad);
        chk(!busy, "R8", {tag, " busy after end"}, busy, 0);
        if (bad) begin
            chk(n_out == 0, "R3", {tag, " no bytes moved"}, n_out, 0);
            chk(n_blk == 0, "R3", {tag, " no block done"}, n_blk, 0);
        end else begin
            int eb = (bad_blk >= 0) ? bad_blk : nb;
            chk(exp_q.size() == 0, tag, "bytes still expected", exp_q.size(), 0);
            chk(n_blk == eb, tag, "blk_done pulses", n_blk, eb);
            chk(n_xfer == ((bad_blk < 0) ? 1 : 0), "R8", {tag, " xfer_done pulses"}, n_xfer, (bad_blk < 0) ? 1 : 0);
            chk(n_stop == ((bad_blk < 0 && opn) ? 1 : 0), "R9", {tag, " stop_req pulses"}, n_stop, (bad_blk < 0 && opn) ? 1 : 0);
            chk(crc_err == (bad_blk >= 0), wr ? "R5" : "R7", {tag, " crc_err"}, crc_err, bad_blk >= 0);
        end
        src_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !out_valid && !in_ready && !cfg_err && !crc_err && !blk_done, "R11", "reset state",
            {busy, out_valid, in_ready, cfg_err, crc_err, blk_done}, 0);
        rst_n = 1'b1;
        run(1, 0, 2, 1, 8,   -1, 0, "R1");   // write 2 x 4 bytes
        run(0, 1, 3, 2, 24,  -1, 1, "R10");  // read 3 x 8, stalled, open-ended
        run(1, 1, 9, 0, 5,   -1, 0, "R2");   // raw write, exponent ignored
        run(0, 0, 7, 0, 3,   -1, 1, "R2");   // raw read, stalled
        run(1, 0, 2, 1, 9,   -1, 0, "R3");   // length mismatch
        run(0, 0, 4, 0, 0,   -1, 0, "R3");   // zero raw length
        run(0, 0, 3, 2, 24,  1,  0, "R7");   // bad CRC on middle block
        run(1, 1, 2, 1, 8,   0,  0, "R5");   // rejected token on first block
        run(1, 1, 4, 2, 48,  -1, 1, "R10");  // write 3 x 16 stalled after errors
        run(0, 0, 0, 3, 4,   -1, 1, "R6");   // one-byte blocks read
        report();
    end
endmodule